// File: doc/BRIEF.md
# Narrow-Bus Conversion Result Readout

This block holds the latest 18-bit conversion result and serves it to a host over a parallel bus that is narrower than the result. A 2-bit mode input picks the format. In word mode the result is read as two 16-bit words, and address line `addr[1]` picks the word. In byte mode it is read as three bytes, and `addr[1:0]` picks the byte. Words appear on bus bits [17:2] and bytes on bus bits [17:10]. Each bus bit has its own output enable, which models tri-state. A bit that is not enabled is driven to zero. The readout behaves the same whether the converter runs as bus master or as bus slave.

A result-valid strobe loads the holding register. While the host has the block selected (chip-select low in a parallel mode), the register is locked. A result that arrives during that time is parked and is applied once the selection ends. All words or bytes of one access therefore come from the same result.

The holding logic is a small state machine with three states:
- `HS_IDLE`: not selected, so new results load directly.
- `HS_LOCK`: selected, with no result waiting.
- `HS_PEND`: selected, with a parked result waiting.

Its transitions are:
- IDLE→LOCK when selection begins.
- IDLE→PEND when selection begins in the same cycle as a result arrives.
- LOCK→PEND when a result arrives during selection.
- LOCK→IDLE and PEND→IDLE when selection ends. Leaving PEND commits the parked result.

Top module: `rdo_readout`

## Requirements
- R1: In word mode (`mode`=1) with `addr[1]`=0, `bus_d[17:2]` shows result[17:2].
- R2: In word mode with `addr[1]`=1, `bus_d[17:16]` shows result[1:0] and `bus_d[15:2]` is zero. `addr[0]` has no effect in word mode.
- R3: In byte mode (`mode`=2), `bus_d[17:10]` shows result[17:10] for `addr`=00 and result[9:2] for `addr`=01.
- R4: In byte mode, `addr`=10 puts result[1:0] on `bus_d[17:16]` with zeros on `bus_d[15:10]`, and `addr`=11 drives all zeros.
- R5: During a read, `bus_oe` is set exactly on [17:2] in word mode and on [17:10] in byte mode. Every `bus_d` bit whose enable is clear is zero.
- R6: When `cs_n` or `rd_n` is high, `bus_oe` and `bus_d` are all zero.
- R7: Mode 0 and mode 3 (serial) never enable the bus, whatever the strobes.
- R8: A `res_valid` pulse while the block is not selected is visible from the next clock edge. Selection means `cs_n` low in mode 1 or 2. Serial mode with `cs_n` low therefore does not count as selected.
- R9: A `res_valid` pulse while selected leaves the bus showing the old result until selection ends. The parked result is then committed on the first edge that samples the block unselected.
- R10: If several results arrive during one selection, the last one is the one committed.
- R11: A result arriving in the same cycle that selection ends is loaded at that edge and takes precedence over any parked result.
- R12: After reset the held result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_valid | input | 1 | Strobe: new conversion result on `res_data` |
| res_data | input | 18 | Conversion result |
| mode | input | 2 | 0 unused, 1 word, 2 byte, 3 serial |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| addr | input | 2 | Word/byte select |
| bus_d | output | 18 | Parallel data bus |
| bus_oe | output | 18 | Per-bit output enable of `bus_d` |

## Verification
Two events can fall in the same cycle: a result strobe arriving, and the host selecting or deselecting the block. The bench forces both orderings. It raises `res_valid` while chip-select is held low, once and twice. It also raises `res_valid` on the very cycle chip-select rises, both with and without an already-parked result. After each case it reads the words back and judges them against the result that R9–R11 say must be visible at that point. A full sweep of mode, address and strobes over walking-one and mixed result patterns covers the slicing.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
    localparam int RES_W   = 18;
    localparam int WORD_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int WORD_LO = RES_W - WORD_W;
    localparam int BYTE_LO = RES_W - BYTE_W;
    localparam int TAIL_W  = RES_W - 2 * BYTE_W;

    typedef enum logic [1:0] {
        MODE_NONE   = 2'd0,
        MODE_WORD   = 2'd1,
        MODE_BYTE   = 2'd2,
        MODE_SERIAL = 2'd3
    } bus_mode_e;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_LOCK = 2'd1,
        HS_PEND = 2'd2
    } hold_state_e;
endpackage

// File: rtl/rdo_hold.sv
module rdo_hold
    import rdo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             access,
    input  logic             res_valid,
    input  logic [RES_W-1:0] res_data,
    output logic [RES_W-1:0] held
);
    hold_state_e      state_q, state_d;
    logic [RES_W-1:0] held_q, held_d;
    logic [RES_W-1:0] pend_q, pend_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE: if (access) state_d = res_valid ? HS_PEND : HS_LOCK;
            HS_LOCK: begin
                if (!access)        state_d = HS_IDLE;
                else if (res_valid) state_d = HS_PEND;
            end
            HS_PEND: if (!access) state_d = HS_IDLE;
            default: state_d = HS_IDLE;
        endcase
    end

    always_comb begin
        held_d = held_q;
        pend_d = pend_q;
        if (!access) begin
            if (res_valid)              held_d = res_data;
            else if (state_q == HS_PEND) held_d = pend_q;
        end else if (res_valid) begin
            pend_d = res_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
            pend_q <= '0;
        end else begin
            held_q <= held_d;
            pend_q <= pend_d;
        end
    end

    assign held = held_q;

    assert_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        access |=> $stable(held_q));
    assert_park_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (access && res_valid) |=> (state_q == HS_PEND));
    assert_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_PEND && !access && !res_valid) |=> (held_q == $past(pend_q)));
    assert_direct_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!access && res_valid) |=> (held_q == $past(res_data)));
endmodule

// File: rtl/rdo_slicer.sv
module rdo_slicer
    import rdo_pkg::*;
(
    input  logic [RES_W-1:0] held,
    input  logic [1:0]       mode,
    input  logic [1:0]       addr,
    input  logic             drive,
    output logic [RES_W-1:0] bus_d,
    output logic [RES_W-1:0] bus_oe
);
    logic [WORD_W-1:0] word_sel;
    logic [BYTE_W-1:0] byte_sel;
    logic [WORD_W-1:0] word_lo;
    logic [BYTE_W-1:0] byte_lo;

    assign word_lo = {held[TAIL_W-1:0], {(WORD_W-TAIL_W){1'b0}}};
    assign byte_lo = {held[TAIL_W-1:0], {(BYTE_W-TAIL_W){1'b0}}};

    always_comb begin
        word_sel = addr[1] ? word_lo : held[RES_W-1 -: WORD_W];
        unique case (addr)
            2'b00:   byte_sel = held[RES_W-1 -: BYTE_W];
            2'b01:   byte_sel = held[RES_W-1-BYTE_W -: BYTE_W];
            2'b10:   byte_sel = byte_lo;
            default: byte_sel = '0;
        endcase
    end

    always_comb begin
        bus_d  = '0;
        bus_oe = '0;
        if (drive) begin
            unique case (bus_mode_e'(mode))
                MODE_WORD: begin
                    bus_d[RES_W-1:WORD_LO]  = word_sel;
                    bus_oe[RES_W-1:WORD_LO] = '1;
                end
                MODE_BYTE: begin
                    bus_d[RES_W-1:BYTE_LO]  = byte_sel;
                    bus_oe[RES_W-1:BYTE_LO] = '1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        assert_undriven_zero_R5: assert ((bus_d & ~bus_oe) == '0)
            else $error("bus bit set without enable");
    end
endmodule

// File: rtl/rdo_readout.sv
module rdo_readout
    import rdo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  logic [RES_W-1:0] res_data,
    input  logic [1:0]       mode,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic [1:0]       addr,
    output logic [RES_W-1:0] bus_d,
    output logic [RES_W-1:0] bus_oe
);
    logic             par_mode;
    logic             access;
    logic             drive;
    logic [RES_W-1:0] held;

    assign par_mode = (bus_mode_e'(mode) == MODE_WORD) || (bus_mode_e'(mode) == MODE_BYTE);
    assign access   = !cs_n && par_mode;
    assign drive    = access && !rd_n;

    rdo_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .access    (access),
        .res_valid (res_valid),
        .res_data  (res_data),
        .held      (held)
    );

    rdo_slicer u_slicer (
        .held   (held),
        .mode   (mode),
        .addr   (addr),
        .drive  (drive),
        .bus_d  (bus_d),
        .bus_oe (bus_oe)
    );

    assert_bus_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (bus_oe == '0));
    assert_nonpar_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 || mode == 2'd3) |-> (bus_oe == '0));
endmodule

// File: tb/rdo_readout_test.sv
module rdo_readout_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [17:0] res_data = '0;
    logic [1:0]  mode = 2'd1;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic [1:0]  addr = 2'd0;
    logic [17:0] bus_d, bus_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    rdo_readout uut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .mode(mode), .cs_n(cs_n), .rd_n(rd_n), .addr(addr),
        .bus_d(bus_d), .bus_oe(bus_oe)
    );

    function automatic logic [17:0] exp_oe(input logic [1:0] m, input logic c, input logic r);
        if (c || r) return '0;
        if (m == 2'd1) return 18'h3FFFC;
        if (m == 2'd2) return 18'h3FC00;
        return '0;
    endfunction

    function automatic logic [17:0] exp_d(input logic [17:0] v, input logic [1:0] m,
                                          input logic [1:0] a, input logic c, input logic r);
        if (c || r) return '0;
        if (m == 2'd1) begin
            if (!a[1]) return (v >> 2) << 2;
            return (v % 4) << 16;
        end
        if (m == 2'd2) begin
            if (a == 2'd0) return (v >> 10) << 10;
            if (a == 2'd1) return ((v >> 2) % 256) << 10;
            if (a == 2'd2) return (v % 4) << 16;
            return '0;
        end
        return '0;
    endfunction

    function automatic string tag_of(input logic [1:0] m, input logic [1:0] a,
                                     input logic c, input logic r);
        if (c || r) return "R6";
        if (m == 2'd0 || m == 2'd3) return "R7";
        if (m == 2'd1) return a[1] ? "R2" : "R1";
        return (a < 2'd2) ? "R3" : "R4";
    endfunction

    task automatic compare(input string tag, input logic [17:0] v);
        logic [17:0] ed, eo;
        ed = exp_d(v, mode, addr, cs_n, rd_n);
        eo = exp_oe(mode, cs_n, rd_n);
        checks++;
        if (bus_d !== ed || bus_oe !== eo) begin
            fails++;
            $display("FAIL %s (R5 enables): mode=%0d addr=%0d cs_n=%0b rd_n=%0b d=%h exp %h oe=%h exp %h",
                     tag, mode, addr, cs_n, rd_n, bus_d, ed, bus_oe, eo);
        end
    endtask

    task automatic apply(input logic [1:0] m, input logic [1:0] a, input logic c, input logic r);
        @(negedge clk);
        mode = m; addr = a; cs_n = c; rd_n = r;
        #1;
    endtask

    task automatic load(input logic [17:0] v);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1; res_valid = 1'b1; res_data = v;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic sweep(input logic [17:0] v);
        for (int m = 0; m < 4; m++)
            for (int a = 0; a < 4; a++)
                for (int s = 0; s < 4; s++) begin
                    apply(m[1:0], a[1:0], s[1], s[0]);
                    compare(tag_of(m[1:0], a[1:0], s[1], s[0]), v);
                end
    endtask

    task automatic read_word(input string tag, input logic [17:0] v);
        for (int a = 0; a < 4; a++) begin
            apply(2'd1, a[1:0], 1'b0, 1'b0);
            compare(tag, v);
        end
        apply(2'd2, 2'd1, 1'b0, 1'b0);
        compare(tag, v);
        apply(2'd1, 2'd0, 1'b1, 1'b1);
    endtask

    task automatic strobe(input logic [17:0] v);
        @(negedge clk);
        res_valid = 1'b1; res_data = v;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state reads as zero through an enabled bus
        apply(2'd1, 2'd0, 1'b0, 1'b0);
        compare("R12", 18'h0);
        apply(2'd2, 2'd1, 1'b0, 1'b0);
        compare("R12", 18'h0);
        sweep(18'h0);

        // R8 / slicing: walking ones and mixed patterns
        for (int i = 0; i < 18; i++) begin
            load(18'h1 << i);
            apply(2'd1, 2'd0, 1'b0, 1'b0);
            compare("R8", 18'h1 << i);
            sweep(18'h1 << i);
        end
        load(18'h3FFFF); sweep(18'h3FFFF);
        load(18'h2A5C3); sweep(18'h2A5C3);
        load(18'h15A3C); sweep(18'h15A3C);

        // R8: serial mode with cs_n low is not a selection, load goes through
        apply(2'd3, 2'd0, 1'b0, 1'b0);
        strobe(18'h0BEEF);
        apply(2'd1, 2'd0, 1'b0, 1'b0);
        compare("R8", 18'h0BEEF);
        apply(2'd1, 2'd0, 1'b1, 1'b1);

        // R9: result during selection is held back until deselect
        load(18'h12345);
        apply(2'd1, 2'd0, 1'b0, 1'b1);
        strobe(18'h3C3C3);
        read_word("R9", 18'h12345);
        @(negedge clk);
        read_word("R9", 18'h3C3C3);

        // R10: two results during one selection, the last one wins
        load(18'h11111);
        apply(2'd2, 2'd0, 1'b0, 1'b1);
        strobe(18'h22222);
        strobe(18'h33333);
        read_word("R10", 18'h11111);
        @(negedge clk);
        read_word("R10", 18'h33333);

        // R11: result in the release cycle beats a parked result
        load(18'h0A0A0);
        apply(2'd1, 2'd0, 1'b0, 1'b1);
        strobe(18'h05050);
        @(negedge clk);
        cs_n = 1'b1; res_valid = 1'b1; res_data = 18'h3E00F;
        @(negedge clk);
        res_valid = 1'b0;
        read_word("R11", 18'h3E00F);

        // R11: result in the release cycle with nothing parked
        apply(2'd1, 2'd0, 1'b0, 1'b1);
        @(negedge clk);
        cs_n = 1'b1; res_valid = 1'b1; res_data = 18'h1D2E3;
        @(negedge clk);
        res_valid = 1'b0;
        read_word("R11", 18'h1D2E3);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule